// File: doc/BRIEF.md
# Lane Writeback Slot Reservation Table

This block guards the single result and bypass path of one execution lane. The lane's functional units have different latencies. Without a guard, a long operation issued early and a short one issued later could both finish in the same cycle and collide on that path. The block keeps a small table with one bit per future cycle. Each bit records whether the result path is already promised for that cycle. An issue request carries the latency of its unit. It is granted only when the bit for its completion cycle is clear. A granted request sets that bit at once.

The table advances by one position every clock. The entry that reaches the current-cycle position raises `wb_valid` for that cycle. This tells the lane's result mux that a reserved result lands now. Request and verdict are plain control pins with no handshake. The scheduler presents a latency code and reads `iss_grant` and `iss_conflict` combinationally in the same cycle. It must treat a refused request as not issued and may offer it again later. A flush input drops every reservation.

Top module: `wbs_lane_guard`

## Requirements
- R1: After reset the table is empty. `wb_valid` stays low, and every request with a nonzero latency is granted until a reservation exists.
- R2: `iss_lat` is a 2-bit code. The values 1, 2 and 3 request a unit of that many cycles. The value 0 means no request: it produces no grant, no conflict and no reservation.
- R3: A request of latency L in cycle t is granted in that same cycle when the completion cycle t+L holds no reservation and `flush` is low.
- R4: A request whose completion cycle is already reserved is refused: `iss_conflict` is high, `iss_grant` is low, and no new reservation is made.
- R5: A request of latency L granted in cycle t raises `wb_valid` in cycle t+L, provided no flush occurs in between.
- R6: Reservations for different completion cycles are independent. A longer-latency request is granted in the same or a later cycle as a shorter one whenever its own completion cycle is free.
- R7: In a cycle with `flush` high, `iss_grant`, `iss_conflict` and `wb_valid` are all low. All reservations are cleared at that clock edge, so later cycles see an empty table.
- R8: `iss_grant` and `iss_conflict` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Drop all reservations; suppresses verdicts and result strobe this cycle |
| iss_lat | input | 2 | Requested unit latency, 0 = no request |
| iss_grant | output | 1 | Request may issue; its completion slot is now reserved |
| iss_conflict | output | 1 | Request refused because its completion slot is taken |
| wb_valid | output | 1 | A reserved result uses the lane's result path this cycle |

## Verification
Two functions routinely meet in one cycle: the table retiring a reservation at its current-cycle position to drive `wb_valid`, and a new request testing and setting another position. Flush can also coincide with both of them. The bench provokes these overlaps with directed sequences, such as a latency-3 issue followed by latency-2 and latency-1 requests aimed at the same cycle, back-to-back latency-1 issues, and a flush landing on a cycle with a pending result and a live request. It then adds a long stretch of random latencies with sparse flushes. Each cycle, a behavioural model keyed by absolute cycle number predicts grant, conflict and result strobe, and the bench compares all three.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
  // verdict of one issue cycle
  typedef struct packed {
    logic grant;
    logic conflict;
  } wbs_verdict_t;
endpackage

// File: rtl/wbs_lat_decode.sv
module wbs_lat_decode #(
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = 2
) (
  input  logic [LAT_W-1:0]   lat,
  output logic               req,
  output logic [MAX_LAT-1:0] target_oh
);
  // bit k of target_oh selects completion slot k+1 cycles ahead
  assign req = (lat != '0);

  for (genvar k = 0; k < MAX_LAT; k++) begin : g_dec
    assign target_oh[k] = (lat == LAT_W'(k + 1));
  end
endmodule

// File: rtl/wbs_slot_table.sv
module wbs_slot_table #(
  parameter int MAX_LAT = 3,
  localparam int DEPTH  = MAX_LAT + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               flush,
  input  logic [MAX_LAT-1:0] set_oh,
  output logic [DEPTH-1:0]   slots
);
  // slots[k]: result path promised k cycles from now
  logic [DEPTH-1:0] slot_q;
  logic [DEPTH-1:0] slot_d;

  for (genvar k = 0; k < DEPTH - 1; k++) begin : g_shift
    // entry k+1 moves to k; a new reservation for k+1 ahead lands at k
    assign slot_d[k] = flush ? 1'b0 : (slot_q[k+1] | set_oh[k]);
  end
  assign slot_d[DEPTH-1] = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_d;
  end

  assign slots = slot_q;
endmodule

// File: rtl/wbs_issue_check.sv
module wbs_issue_check
  import wbs_pkg::*;
#(
  parameter int MAX_LAT = 3,
  localparam int DEPTH  = MAX_LAT + 1
) (
  input  logic               req,
  input  logic               flush,
  input  logic [MAX_LAT-1:0] target_oh,
  input  logic [DEPTH-1:0]   slots,
  output wbs_verdict_t       verdict
);
  logic taken;

  // slots[0] is the current cycle and is never a target
  assign taken = |(target_oh & slots[DEPTH-1:1]);

  always_comb begin
    verdict.grant    = 1'b0;
    verdict.conflict = 1'b0;
    if (req && !flush) begin
      verdict.grant    = !taken;
      verdict.conflict = taken;
    end
  end
endmodule

// File: rtl/wbs_lane_guard.sv
module wbs_lane_guard
  import wbs_pkg::*;
#(
  parameter int MAX_LAT = 3,
  parameter int LAT_W   = 2,
  localparam int DEPTH  = MAX_LAT + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [LAT_W-1:0] iss_lat,
  output logic             iss_grant,
  output logic             iss_conflict,
  output logic             wb_valid
);
  logic               req;
  logic [MAX_LAT-1:0] target_oh;
  logic [MAX_LAT-1:0] set_oh;
  logic [DEPTH-1:0]   slots;
  wbs_verdict_t       verdict;

  wbs_lat_decode #(.MAX_LAT(MAX_LAT), .LAT_W(LAT_W)) u_dec (
    .lat       (iss_lat),
    .req       (req),
    .target_oh (target_oh)
  );

  wbs_issue_check #(.MAX_LAT(MAX_LAT)) u_chk (
    .req       (req),
    .flush     (flush),
    .target_oh (target_oh),
    .slots     (slots),
    .verdict   (verdict)
  );

  assign set_oh = target_oh & {MAX_LAT{verdict.grant}};

  wbs_slot_table #(.MAX_LAT(MAX_LAT)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .set_oh (set_oh),
    .slots  (slots)
  );

  assign iss_grant    = verdict.grant;
  assign iss_conflict = verdict.conflict;
  assign wb_valid     = slots[0] & ~flush;
endmodule

// File: rtl/wbs_lane_guard_sva.sv
module wbs_lane_guard_sva #(
  parameter int LAT_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic [LAT_W-1:0] iss_lat,
  input logic             iss_grant,
  input logic             iss_conflict,
  input logic             wb_valid
);
  assert_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(iss_grant && iss_conflict));

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_lat == '0) |-> (!iss_grant && !iss_conflict));

  assert_flush_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    flush |-> (!iss_grant && !iss_conflict && !wb_valid));

  assert_flush_clear_R7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !wb_valid);

  assert_lat1_lands_R5: assert property (@(posedge clk) disable iff (rst)
    (iss_grant && iss_lat == LAT_W'(1)) |=> (wb_valid || flush));

  assert_refuse_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (iss_conflict && iss_lat == LAT_W'(1)) |=> (wb_valid || flush));
endmodule

bind wbs_lane_guard wbs_lane_guard_sva #(.LAT_W(LAT_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .flush        (flush),
  .iss_lat      (iss_lat),
  .iss_grant    (iss_grant),
  .iss_conflict (iss_conflict),
  .wb_valid     (wb_valid)
);

// File: tb/tb_wbs_lane_guard.sv
module tb_wbs_lane_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       flush = 1'b0;
  logic [1:0] iss_lat = 2'd0;
  logic       iss_grant, iss_conflict, wb_valid;

  int n_checks = 0;
  int n_errors = 0;
  int cyc = 0;
  bit resv[int];

  always #2 clk = ~clk;

  wbs_lane_guard dut (
    .clk(clk), .rst(rst), .flush(flush), .iss_lat(iss_lat),
    .iss_grant(iss_grant), .iss_conflict(iss_conflict), .wb_valid(wb_valid)
  );

  task automatic check(input bit act, input bit exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: actual=%0b expected=%0b", what, cyc, act, exp);
    end
  endtask

  function automatic bit busy(int c);
    return resv.exists(c) && resv[c];
  endfunction

  // one cycle: drive after negedge, compare, then advance model at posedge
  task automatic step(input int lat, input bit fl, input string tag);
    bit e_wb, e_gr, e_cf;
    @(negedge clk);
    iss_lat = 2'(lat);
    flush   = fl;
    #1;
    e_wb = !fl && busy(cyc);
    e_gr = (lat != 0) && !fl && !busy(cyc + lat);
    e_cf = (lat != 0) && !fl && busy(cyc + lat);
    check(wb_valid,     e_wb, {tag, " R5 wb_valid"});
    check(iss_grant,    e_gr, {tag, " R3 grant"});
    check(iss_conflict, e_cf, {tag, " R4 conflict"});
    @(posedge clk);
    if (fl) resv.delete();
    else if (e_gr) resv[cyc + lat] = 1'b1;
    cyc++;
  endtask

  initial begin
    #400000;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check(wb_valid, 1'b0, "R1 reset wb_valid");
    check(iss_grant, 1'b0, "R1 reset grant");
    rst = 1'b0;
    // R1: empty table grants first request
    step(3, 0, "R1 first");
    // R4: same cycle targeted by latency 2 and 1
    step(2, 0, "R4 lat2 collide");
    step(1, 0, "R4 lat1 collide");
    step(0, 0, "R2 idle");
    // R6: long then short, different cycles
    step(3, 0, "R6 lat3");
    step(1, 0, "R6 lat1");
    step(1, 0, "R6 lat1 again");
    step(0, 0, "R2 idle");
    step(0, 0, "R2 idle");
    // back-to-back latency 1
    for (int i = 0; i < 5; i++) step(1, 0, "R3 b2b");
    // R7: flush with pending result and live request
    step(3, 0, "R7 setup");
    step(2, 0, "R7 setup");
    step(1, 1, "R7 flush");
    step(0, 0, "R7 after flush");
    step(0, 0, "R7 after flush");
    step(1, 0, "R7 regrant");
    step(0, 0, "R5 land");
    // random stretch
    for (int i = 0; i < 2000; i++) begin
      step(int'($urandom_range(0, 3)), ($urandom_range(0, 31) == 0), "R8 random");
      check(iss_grant && iss_conflict, 1'b0, "R8 exclusive");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule